// File: doc/BRIEF.md
# Transmit Burst Timing Sequencer

This block times one uplink transmit burst on a quarter-bit time base. Ahead of each burst a host writes the burst bits (guard, tail and payload) one at a time into a staging buffer, and presents the ramp-up and ramp-down delays on two level inputs. The burst opens when the timing-enable input rises while the uplink-on input is high. At that point the block copies the staging buffer, together with both delays, into working storage. Writes made later do not reach the burst in flight.

While the burst runs, the block presents one buffer bit per bit period (four quarter bits) on the modulator-data output. It fires a one-clock ramp-up strobe and a one-clock ramp-down strobe for an external power-shaping stage. After the enable drops, modulation carries on for a fixed tail of 32 quarter bits, and then a one-clock done pulse is issued.

An internal prescaler divides the clock into quarter-bit ticks. The enable and all sequencing events are handled only on those ticks. Dropping uplink-on aborts the burst on the next clock.

The controller has three states:

- SEQ_IDLE: waiting for a burst.
- SEQ_RUN: the enable is still high.
- SEQ_TAIL: the fixed tail after the enable falls.

Its transitions are:

- start (SEQ_IDLE to SEQ_RUN): on a tick, uplink-on high and a rising enable.
- fall (SEQ_RUN to SEQ_TAIL): on a tick, enable low.
- tail_end (SEQ_TAIL to SEQ_IDLE): on the tick that ends the 32nd tail quarter.
- abort (SEQ_RUN or SEQ_TAIL to SEQ_IDLE): on any clock where uplink-on is low.

Top module: `tbs_burst_seq`

## Requirements
- R1: State changes other than abort happen only on quarter-bit ticks. A tick is one clock in every QB_DIV clocks, counted by a free-running prescaler from reset. The enable is sampled only on ticks, so data_valid rises within 1 to QB_DIV clocks after the enable is raised.
- R2: A burst starts only on a tick where the enable is high, the enable was low at the previous tick, and uplink-on is high. An enable raised while uplink-on is low starts nothing.
- R3: The buffer contents and both delays are captured at the start tick. Host writes after that point do not change the bits of the current burst.
- R4: The modulator bit is read from the working buffer at address floor(q/4), where q is the number of quarter bits elapsed since the start tick. Reading begins at address 0. Once floor(q/4) is DEPTH or more, the bit is 1. mod_bit is 0 when no burst is active.
- R5: data_valid stays high for QB_DIV × (N + 32) clocks, where N is the number of quarter bits spent in SEQ_RUN.
- R6: ramp_up is a single one-clock pulse, asserted when q equals the captured ramp-up delay. A delay of 0 makes it coincide with the first valid cycle.
- R7: ramp_dn is a single one-clock pulse, asserted when the number of tail quarters elapsed equals the captured ramp-down delay (0 to 31). It always falls inside the tail, while data_valid is high.
- R8: done is a one-clock pulse issued in the first cycle after the tail ends, when data_valid is already low.
- R9: If uplink-on is low during a burst, data_valid and all strobes are low on the next clock, and no done pulse follows.
- R10: Enable edges that occur during a burst are ignored. A new burst needs a fresh rising edge seen in SEQ_IDLE.
- R11: After reset all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ul_on | input | 1 | Uplink-on window; low aborts a burst |
| burst_en | input | 1 | Timing enable; its high time sets the burst length |
| wr_en | input | 1 | Staging buffer write strobe |
| wr_addr | input | $clog2(DEPTH) | Staging buffer bit address |
| wr_bit | input | 1 | Bit value to write |
| rup_dly | input | UP_W | Ramp-up delay in quarter bits from the start |
| rdn_dly | input | $clog2(TAIL_QB) | Ramp-down delay in quarter bits from the fall |
| data_valid | output | 1 | High while a burst is being modulated |
| mod_bit | output | 1 | Current burst bit to the modulator |
| ramp_up | output | 1 | One-clock ramp-up strobe |
| ramp_dn | output | 1 | One-clock ramp-down strobe |
| done | output | 1 | One-clock end-of-burst pulse |

## Verification
If the quarter count goes wrong, mod_bit shows a buffer bit with the wrong index within one bit period. The burst length at done is off by a multiple of QB_DIV clocks. A tail counter or state fault shows up as a data_valid window of the wrong length, or as a missing or repeated done at the end of that burst. A stale copy of the delays moves the ramp strobes by whole quarter bits. Because the bench compares every output on every clock, each of these appears in the first cycle where the output differs.

// File: rtl/tbs_pkg.sv
package tbs_pkg;
    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_RUN  = 2'd1,
        SEQ_TAIL = 2'd2
    } seq_state_t;
endpackage

// File: rtl/tbs_qb_timer.sv
// Free-running prescaler: one tick per QB_DIV clocks marks a quarter bit.
module tbs_qb_timer #(
    parameter int QB_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (QB_DIV > 1) ? $clog2(QB_DIV) : 1;

    logic [CW-1:0] div_cnt;

    assign tick = (div_cnt == CW'(QB_DIV - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    div_cnt <= '0;
        else if (tick) div_cnt <= '0;
        else           div_cnt <= div_cnt + 1'b1;
    end
endmodule

// File: rtl/tbs_burst_store.sv
// Staging buffer written by the host, plus a working copy taken at burst start.
module tbs_burst_store #(
    parameter int DEPTH = 64
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [$clog2(DEPTH)-1:0] wr_addr,
    input  logic                     wr_bit,
    input  logic                     capture,
    input  logic [$clog2(DEPTH):0]   rd_idx,
    output logic                     rd_bit
);
    localparam int AW = $clog2(DEPTH);

    logic [DEPTH-1:0] stage_q;
    logic [DEPTH-1:0] live_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= '0;
            live_q  <= '0;
        end else begin
            if (wr_en)   stage_q[wr_addr] <= wr_bit;
            if (capture) live_q <= stage_q;
        end
    end

    // Past the last stored bit the burst is padded with ones.
    assign rd_bit = (rd_idx < (AW+1)'(DEPTH)) ? live_q[rd_idx[AW-1:0]] : 1'b1;
endmodule

// File: rtl/tbs_burst_seq.sv
module tbs_burst_seq
    import tbs_pkg::*;
#(
    parameter int DEPTH   = 64,
    parameter int QB_DIV  = 2,
    parameter int TAIL_QB = 32,
    parameter int UP_W    = 6
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       ul_on,
    input  logic                       burst_en,
    input  logic                       wr_en,
    input  logic [$clog2(DEPTH)-1:0]   wr_addr,
    input  logic                       wr_bit,
    input  logic [UP_W-1:0]            rup_dly,
    input  logic [$clog2(TAIL_QB)-1:0] rdn_dly,
    output logic                       data_valid,
    output logic                       mod_bit,
    output logic                       ramp_up,
    output logic                       ramp_dn,
    output logic                       done
);
    localparam int AW = $clog2(DEPTH);
    localparam int QW = AW + 3;
    localparam int TW = $clog2(TAIL_QB);

    seq_state_t        state, next_state;
    logic              tick, en_q;
    logic [QW-1:0]     qcnt, q_inc;
    logic [TW-1:0]     tcnt, rdn_q;
    logic [UP_W-1:0]   rup_q;
    logic              busy, start, fall, tail_end, abort;
    logic              up_hit, dn_hit, rd_bit;

    tbs_qb_timer #(.QB_DIV(QB_DIV)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    tbs_burst_store #(.DEPTH(DEPTH)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_bit  (wr_bit),
        .capture (start),
        .rd_idx  (qcnt[QW-1:2]),
        .rd_bit  (rd_bit)
    );

    assign busy     = (state != SEQ_IDLE);
    assign abort    = busy && !ul_on;
    assign start    = tick && (state == SEQ_IDLE) && ul_on && burst_en && !en_q;
    assign fall     = tick && (state == SEQ_RUN) && ul_on && !burst_en;
    assign tail_end = tick && (state == SEQ_TAIL) && ul_on && (tcnt == TW'(TAIL_QB - 1));
    assign q_inc    = (&qcnt) ? qcnt : qcnt + 1'b1;
    assign up_hit   = tick && busy && !abort && !tail_end && (q_inc == QW'(rup_q));
    assign dn_hit   = tick && (state == SEQ_TAIL) && !abort && !tail_end
                      && ((tcnt + 1'b1) == rdn_q);

    // Next-state logic
    always_comb begin
        next_state = state;
        unique case (state)
            SEQ_IDLE: if (start) next_state = SEQ_RUN;
            SEQ_RUN: begin
                if (abort)     next_state = SEQ_IDLE;
                else if (fall) next_state = SEQ_TAIL;
            end
            SEQ_TAIL: begin
                if (abort || tail_end) next_state = SEQ_IDLE;
            end
            default: next_state = SEQ_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= SEQ_IDLE;
        else        state <= next_state;
    end

    // Quarter-bit and tail counters, captured delays, enable history
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q  <= 1'b0;
            qcnt  <= '0;
            tcnt  <= '0;
            rup_q <= '0;
            rdn_q <= '0;
        end else begin
            if (tick) en_q <= burst_en;
            if (start) begin
                qcnt  <= '0;
                rup_q <= rup_dly;
                rdn_q <= rdn_dly;
            end else if (tick && busy) begin
                qcnt <= q_inc;
            end
            if (fall)                             tcnt <= '0;
            else if (tick && state == SEQ_TAIL)   tcnt <= tcnt + 1'b1;
        end
    end

    // Output strobes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ramp_up <= 1'b0;
            ramp_dn <= 1'b0;
            done    <= 1'b0;
        end else begin
            ramp_up <= (start && rup_dly == '0) || up_hit;
            ramp_dn <= (fall && rdn_q == '0) || dn_hit;
            done    <= tail_end;
        end
    end

    always_comb begin
        data_valid = busy;
        mod_bit    = busy && rd_bit;
    end
endmodule

// File: rtl/tbs_burst_seq_chk.sv
module tbs_burst_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic ul_on,
    input logic burst_en,
    input logic data_valid,
    input logic ramp_up,
    input logic ramp_dn,
    input logic done
);
    // R2: a burst only opens after enable and uplink-on were both high
    a_r2_start_gated: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(data_valid) |-> $past(ul_on) && $past(burst_en));

    // R6: ramp-up strobe lasts one clock
    a_r6_up_single: assert property (@(posedge clk) disable iff (!rst_n)
        ramp_up |=> !ramp_up);

    // R7: ramp-down strobe only while the burst is still modulating
    a_r7_dn_in_burst: assert property (@(posedge clk) disable iff (!rst_n)
        ramp_dn |-> data_valid);

    // R8: done is a single pulse right after the burst closes
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r8_done_after_burst: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !data_valid && $past(data_valid));

    // R9: uplink-on low ends the burst on the next clock
    a_r9_abort: assert property (@(posedge clk) disable iff (!rst_n)
        data_valid && !ul_on |=> !data_valid && !done);
endmodule

bind tbs_burst_seq tbs_burst_seq_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ul_on      (ul_on),
    .burst_en   (burst_en),
    .data_valid (data_valid),
    .ramp_up    (ramp_up),
    .ramp_dn    (ramp_dn),
    .done       (done)
);

// File: tb/sim_tbs_burst_seq.sv
`timescale 1ns/1ps
module sim_tbs_burst_seq;
    localparam int DEPTH = 64;
    localparam int QBD   = 2;
    localparam int TAIL  = 32;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ul_on = 1'b0, burst_en = 1'b0, wr_en = 1'b0, wr_bit = 1'b0;
    logic [5:0] wr_addr = '0;
    logic [5:0] rup_dly = '0;
    logic [4:0] rdn_dly = '0;
    logic       data_valid, mod_bit, ramp_up, ramp_dn, done;

    int n_checks = 0, n_fail = 0, cyc = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    tbs_burst_seq u0 (
        .clk(clk), .rst_n(rst_n), .ul_on(ul_on), .burst_en(burst_en),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_bit(wr_bit),
        .rup_dly(rup_dly), .rdn_dly(rdn_dly),
        .data_valid(data_valid), .mod_bit(mod_bit),
        .ramp_up(ramp_up), .ramp_dn(ramp_dn), .done(done)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d (t=%0t)", tag, act, exp, $time);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    endtask

    // Behavioural reference model, stepped on every rising edge
    int m_div = 0, m_st = 0, m_q = 0, m_t = 0, m_enp = 0, m_rup = 0, m_rdn = 0, m_runq = 0;
    bit m_stage[DEPTH];
    bit m_live[DEPTH];
    bit m_up = 0, m_dn = 0, m_done = 0;

    always @(posedge clk) begin
        bit tk;
        cyc++;
        if (!rst_n) begin
            m_div = 0; m_st = 0; m_q = 0; m_t = 0; m_enp = 0;
            m_up = 0; m_dn = 0; m_done = 0;
            foreach (m_stage[i]) begin m_stage[i] = 0; m_live[i] = 0; end
        end else begin
            tk = (m_div == QBD - 1);
            m_div = (m_div + 1) % QBD;
            m_up = 0; m_dn = 0; m_done = 0;
            if (m_st != 0 && !ul_on) begin
                m_st = 0;
            end else if (tk) begin
                if (m_st == 0) begin
                    if (ul_on && burst_en && !m_enp) begin
                        m_live = m_stage;
                        m_rup = rup_dly; m_rdn = rdn_dly;
                        m_st = 1; m_q = 0;
                        if (m_rup == 0) m_up = 1;
                    end
                end else if (m_st == 1) begin
                    m_q++;
                    if (m_q == m_rup) m_up = 1;
                    if (!burst_en) begin
                        m_st = 2; m_t = 0; m_runq = m_q;
                        if (m_rdn == 0) m_dn = 1;
                    end
                end else begin
                    if (m_t == TAIL - 1) begin
                        m_st = 0; m_done = 1;
                    end else begin
                        m_q++; m_t++;
                        if (m_q == m_rup) m_up = 1;
                        if (m_t == m_rdn) m_dn = 1;
                    end
                end
            end
            if (tk) m_enp = burst_en;
            if (wr_en) m_stage[wr_addr] = wr_bit;
        end
    end

    // Per-clock comparison plus per-burst counts
    int vcnt = 0, upcnt = 0, dncnt = 0;
    always @(negedge clk) begin
        int eb;
        if (rst_n && !finished) begin
            eb = (m_st != 0) ? (((m_q >> 2) < DEPTH) ? int'(m_live[m_q >> 2]) : 1) : 0;
            check(data_valid == (m_st != 0), "R5 data_valid", data_valid, int'(m_st != 0));
            check(mod_bit == eb[0], "R4 mod_bit", mod_bit, eb);
            check(ramp_up == m_up, "R6 ramp_up", ramp_up, m_up);
            check(ramp_dn == m_dn, "R7 ramp_dn", ramp_dn, m_dn);
            check(done == m_done, "R8 done", done, m_done);
            if (data_valid) vcnt++;
            if (ramp_up) upcnt++;
            if (ramp_dn) dncnt++;
            if (done) begin
                check(vcnt == QBD * (m_runq + TAIL), "R5 burst length", vcnt, QBD * (m_runq + TAIL));
                check(upcnt == 1, "R6 one ramp_up per burst", upcnt, 1);
                check(dncnt == 1, "R7 one ramp_dn per burst", dncnt, 1);
            end
            if (!data_valid) begin vcnt = 0; upcnt = 0; dncnt = 0; end
        end
    end

    // Watchdog
    always @(posedge clk) begin
        if (cyc > 100000 && !finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=<100000", cyc);
            summary();
        end
    end

    task automatic clocks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_done(input string tag);
        int k = 0;
        while (!done && k < 400) begin @(negedge clk); k++; end
        check(done == 1'b1, tag, done, 1);
    endtask

    initial begin
        clocks(4);
        check(data_valid == 0 && mod_bit == 0 && ramp_up == 0 && ramp_dn == 0 && done == 0,
              "R11 reset outputs", {data_valid, mod_bit, ramp_up, ramp_dn, done}, 0);
        rst_n = 1'b1;

        // Load a pattern into the staging buffer
        for (int i = 0; i < DEPTH; i++) begin
            wr_en = 1; wr_addr = 6'(i); wr_bit = ((i * 7 + 3) % 5) < 2;
            @(negedge clk);
        end
        wr_en = 0;

        // Burst 1: long enable to run past the stored bits
        rup_dly = 6'd5; rdn_dly = 5'd3; ul_on = 1;
        clocks(2);
        burst_en = 1;
        begin
            int lat = 0;
            while (!data_valid && lat < 10) begin @(negedge clk); lat++; end
            check(lat >= 1 && lat <= QBD, "R1 start on quarter tick", lat, QBD);
        end
        clocks(540);
        burst_en = 0;
        wait_done("R8 burst 1 done");
        clocks(3);

        // Burst 2: zero delays, host rewrites the buffer mid-burst, enable re-raised in tail
        rup_dly = 6'd0; rdn_dly = 5'd0;
        burst_en = 1;
        clocks(4);
        for (int i = 0; i < 16; i++) begin
            wr_en = 1; wr_addr = 6'(i); wr_bit = ~(((i * 7 + 3) % 5) < 2);
            @(negedge clk);
        end
        wr_en = 0;
        check(data_valid == 1, "R3 burst still running after writes", data_valid, 1);
        burst_en = 0;
        clocks(10);
        burst_en = 1;
        wait_done("R8 burst 2 done");
        clocks(40);
        check(data_valid == 0, "R10 enable edge in tail ignored", data_valid, 0);
        burst_en = 0;
        clocks(4);

        // Uplink-on low: enable must not start a burst
        ul_on = 0; burst_en = 1;
        begin
            int seen = 0;
            for (int i = 0; i < 20; i++) begin @(negedge clk); if (data_valid) seen++; end
            check(seen == 0, "R2 no start without uplink-on", seen, 0);
        end
        burst_en = 0;
        clocks(4);

        // Burst 3: late ramp-up in the tail, ramp-down at the last tail quarter
        ul_on = 1; rup_dly = 6'd40; rdn_dly = 5'd31;
        clocks(2);
        burst_en = 1;
        clocks(40);
        burst_en = 0;
        wait_done("R8 burst 3 done");
        clocks(3);

        // Burst 4: abort by dropping uplink-on
        rup_dly = 6'd2; rdn_dly = 5'd1;
        burst_en = 1;
        clocks(20);
        ul_on = 0;
        @(negedge clk);
        check(data_valid == 0, "R9 abort clears burst", data_valid, 0);
        begin
            int dseen = 0;
            for (int i = 0; i < 80; i++) begin @(negedge clk); if (done) dseen++; end
            check(dseen == 0, "R9 no done after abort", dseen, 0);
        end
        burst_en = 0;
        clocks(4);
        summary();
    end
endmodule